// File: doc/BRIEF.md
# Select-Framed SPI Slave Byte Port

This block is the receive and transmit engine of a byte-wide serial peripheral interface slave that runs in clock mode 0. The master drives the serial clock, the serial data input and an active-low select line. The block samples incoming data on each rising serial-clock edge with the most significant bit first. It shifts its own transmit byte out on the falling edges. On the host side, a finished byte is presented through a valid/ready receive stream. The next outgoing byte is accepted through a valid/ready transmit stream that holds a single byte.

The select line frames the traffic. While select is low the slave counts bits and may drive its serial output. The output enable also requires the host's `miso_en` input to be high. While select is high, the serial output enable is released and every clock or data transition on the bus is ignored. When select rises, the bit counter and both shift registers are cleared at once, so a partly shifted byte is discarded. This keeps the slave aligned to the master's byte boundaries. The next fall of select preloads the pending transmit byte. Several bytes may follow each other within one select-low period.

The three bus inputs pass through two-flop synchronizers into `clk`, and their edges are detected there. For this reason `clk` must run at least four times faster than the serial clock. The bus side cannot be stalled. A receive byte that the host has not taken is overwritten by the next completed byte, and `rx_valid` stays high. A transmit write is accepted only while the holding register is empty. The holding register is emptied each time its byte is loaded into the shifter.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_data` is 0, `tx_ready` is 1, `spi_miso` is 0 and `spi_miso_oe` is 0.
- R2: While select is low, `spi_mosi` is sampled on every rising `spi_sck` edge, most significant bit first. On the eighth rising edge, `rx_data` takes the assembled byte and `rx_valid` goes to 1. A bus pin change takes effect at the third rising `clk` edge after it.
- R3: When select falls, the transmit byte is loaded into the shifter, so its most significant bit is on `spi_miso` before the first rising `spi_sck`. Each falling `spi_sck` edge moves the next bit onto `spi_miso`.
- R4: `spi_miso_oe` is 1 exactly when `miso_en` is 1 and the synchronized select is low. Otherwise it is 0.
- R5: When select rises, the bit counter and the shift registers are cleared at once. An aborted byte never sets `rx_valid` and never changes `rx_data`. The next select-low period starts a fresh byte on both data lines.
- R6: `rx_valid` drops after the `clk` edge at which it is high together with `rx_ready`. A byte that completes while `rx_valid` is still high replaces `rx_data`, and `rx_valid` stays 1. A byte that completes in the same cycle as a handshake also leaves `rx_valid` at 1.
- R7: `tx_ready` is 1 while the transmit holding register is empty. A write with `tx_valid` and `tx_ready` both high fills the register and drops `tx_ready`. Loading the byte into the shifter empties the register again. If the register is empty when a byte is loaded, the slave sends 8'h00.
- R8: Within one select-low period, the falling `spi_sck` edge that follows a completed byte loads the next transmit byte. Reception then continues with a new byte.
- R9: While select is high, transitions on `spi_sck` and `spi_mosi` change neither `rx_valid` nor `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the serial data pad (0 = high impedance) |
| miso_en | input | 1 | Host permission to drive the serial output |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Last received byte |
| tx_valid | input | 1 | Host offers the next transmit byte |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 8 | Next transmit byte |

## Verification
Every bus-side result comes at a fixed distance from the pin change that causes it. A clock or select edge acts at the third `clk` edge after the pin moves. `spi_miso_oe` follows select after the second edge. Host handshakes act at the next edge. The bench holds a behavioural model that stores the raw pin values of the past edges and applies the same counts. It compares `rx_valid`, `rx_data`, `tx_ready`, `spi_miso` and `spi_miso_oe` 2 ns after every rising `clk`. The bench moves the serial pins only every eight `clk` cycles. Its directed checks therefore sample well after each result has settled.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

  // Synchronized view of one bus line.
  typedef struct packed {
    logic lvl;   // synchronized level
    logic rise;  // 0 -> 1 seen this cycle
    logic fall;  // 1 -> 0 seen this cycle
  } line_evt_t;

  // Indices of the bus lines in the synchronizer bank.
  localparam int LINE_SCK  = 0;
  localparam int LINE_MOSI = 1;
  localparam int LINE_SEL  = 2;
  localparam int LINES     = 3;

endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync
  import spi_sel_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      din,
  output line_evt_t evt
);

  // chain[0..STAGES-1] synchronize, chain[STAGES] holds the prior level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES + 1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], din};
  end

  always_comb begin
    evt.lvl  = chain[STAGES-1];
    evt.rise = chain[STAGES-1] & ~chain[STAGES];
    evt.fall = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/spi_sel_core.sv
module spi_sel_core
  import spi_sel_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL  = '0,
  localparam int              CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_evt_t         sck,
  input  logic              mosi_lvl,
  input  line_evt_t         sel,
  input  logic [DATA_W-1:0] tx_hold,
  input  logic              tx_full,
  output logic              consume,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso,
  output logic              abort,
  output logic              sel_act,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_next;
  logic [DATA_W-1:0] load_val;
  logic              at_last;
  logic              in_frame;
  logic              reload_mid;

  always_comb begin
    sel_act    = ~sel.lvl;
    abort      = sel.rise;
    in_frame   = sel_act & ~sel.fall;
    at_last    = (cnt_q == LAST);
    rx_next    = {rx_sh[DATA_W-2:0], mosi_lvl};
    load_val   = tx_full ? tx_hold : FILL;
    reload_mid = in_frame & sck.fall & (cnt_q == '0);
    consume    = sel.fall | reload_mid;
    byte_done  = in_frame & sck.rise & at_last;
    rx_byte    = rx_next;
    miso       = tx_sh[DATA_W-1];
    bit_cnt    = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
    end else if (sel.rise) begin
      cnt_q <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
    end else if (sel.fall) begin
      cnt_q <= '0;
      rx_sh <= '0;
      tx_sh <= load_val;
    end else if (sel_act) begin
      if (sck.rise) begin
        rx_sh <= rx_next;
        cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end else if (sck.fall) begin
        tx_sh <= (cnt_q == '0) ? load_val : {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_sel_host.sv
module spi_sel_host #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              consume,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] tx_hold,
  output logic              tx_full
);

  logic wr;

  always_comb begin
    tx_ready = ~tx_full;
    wr       = tx_valid & ~tx_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_done) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (wr) begin
      tx_full <= 1'b1;
      tx_hold <= tx_data;
    end else if (consume) begin
      tx_full <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_sel_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              miso_en,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data
);

  localparam logic [LINES-1:0] IDLE_LVL = LINES'(1) << LINE_SEL;

  logic [LINES-1:0]  raw;
  line_evt_t         evt [LINES];
  logic              consume;
  logic              byte_done;
  logic [DATA_W-1:0] rx_byte;
  logic              abort;
  logic              sel_act;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_hold;
  logic              tx_full;

  always_comb begin
    raw            = '0;
    raw[LINE_SCK]  = spi_sck;
    raw[LINE_MOSI] = spi_mosi;
    raw[LINE_SEL]  = spi_sel_n;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    spi_sel_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LVL[g])
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw[g]),
      .evt   (evt[g])
    );
  end

  spi_sel_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (evt[LINE_SCK]),
    .mosi_lvl  (evt[LINE_MOSI].lvl),
    .sel       (evt[LINE_SEL]),
    .tx_hold   (tx_hold),
    .tx_full   (tx_full),
    .consume   (consume),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso),
    .abort     (abort),
    .sel_act   (sel_act),
    .bit_cnt   (bit_cnt)
  );

  spi_sel_host #(
    .DATA_W (DATA_W)
  ) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .consume   (consume),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_hold   (tx_hold),
    .tx_full   (tx_full)
  );

  assign spi_miso_oe = miso_en & sel_act;

endmodule

// File: rtl/spi_sel_checker.sv
module spi_sel_checker #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              spi_miso_oe,
  input logic              miso_en,
  input logic              byte_done,
  input logic              abort,
  input logic              sel_act,
  input logic [CNT_W-1:0]  bit_cnt
);

  AST_DONE_RAISES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_valid); // R2

  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> (miso_en && sel_act)); // R4

  AST_ABORT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (bit_cnt == '0)); // R5

  AST_ABORT_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> $stable(rx_data)); // R5

  AST_UNTAKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !byte_done) |=> (rx_valid && $stable(rx_data))); // R6

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R7

  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |-> !byte_done); // R9

endmodule

bind spi_sel_slave spi_sel_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .spi_miso_oe (spi_miso_oe),
  .miso_en     (miso_en),
  .byte_done   (byte_done),
  .abort       (abort),
  .sel_act     (sel_act),
  .bit_cnt     (bit_cnt)
);

// File: tb/spi_sel_slave_bench.sv
`timescale 1ns/1ps
module spi_sel_slave_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_mosi = 1'b0, spi_sel_n = 1'b1;
  logic       spi_miso, spi_miso_oe;
  logic       miso_en = 1'b0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_sel_slave u_spi_sel_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_sel_n(spi_sel_n), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .miso_en(miso_en), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // history of raw pins {sel, mosi, sck} taken at each rising clk edge
  logic [2:0] hist [$];
  logic       m_rxv, m_txfull;
  logic [7:0] m_rxd, m_txhold, m_txsh, m_rxsh;
  int         m_cnt;

  always @(posedge clk) begin
    logic [2:0] now_p, old_p;
    logic sel_fall, sel_rise, sck_rise, sck_fall, sel_lo, done, consume, wr;
    logic [7:0] v, load;
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back(3'b100);
      m_rxv = 0; m_rxd = 0; m_txfull = 0; m_txhold = 0;
      m_txsh = 0; m_rxsh = 0; m_cnt = 0;
    end else begin
      hist.push_back({spi_sel_n, spi_mosi, spi_sck});
      if (hist.size() > 4) void'(hist.pop_front());
      now_p = hist[hist.size()-3];  // pins two edges back
      old_p = hist[hist.size()-4];  // pins three edges back
      sel_lo   = !now_p[2];
      sel_fall = old_p[2] && !now_p[2];
      sel_rise = !old_p[2] && now_p[2];
      sck_rise = now_p[0] && !old_p[0];
      sck_fall = !now_p[0] && old_p[0];
      done = 0; consume = 0; v = 0;
      wr = tx_valid && !m_txfull;
      load = m_txfull ? m_txhold : 8'h00;
      if (sel_rise) begin
        m_cnt = 0; m_rxsh = 0; m_txsh = 0;
      end else if (sel_fall) begin
        m_cnt = 0; m_rxsh = 0; m_txsh = load; consume = 1;
      end else if (sel_lo) begin
        if (sck_rise) begin
          v = {m_rxsh[6:0], now_p[1]};
          m_rxsh = v;
          if (m_cnt == 7) begin done = 1; m_cnt = 0; end
          else m_cnt++;
        end else if (sck_fall) begin
          if (m_cnt == 0) begin m_txsh = load; consume = 1; end
          else m_txsh = m_txsh << 1;
        end
      end
      if (done) begin m_rxv = 1; m_rxd = v; end
      else if (m_rxv && rx_ready) m_rxv = 0;
      if (wr) begin m_txfull = 1; m_txhold = tx_data; end
      else if (consume) m_txfull = 0;
    end
    #2;
    check(rx_valid == m_rxv, "R2 rx_valid per-cycle", rx_valid, m_rxv);
    check(rx_data == m_rxd, "R2 rx_data per-cycle", rx_data, m_rxd);
    check(tx_ready == !m_txfull, "R7 tx_ready per-cycle", tx_ready, !m_txfull);
    check(spi_miso == m_txsh[7], "R3 miso per-cycle", spi_miso, m_txsh[7]);
    check(spi_miso_oe == (miso_en && rst_n && !hist[hist.size()-2][2]),
          "R4 miso_oe per-cycle", spi_miso_oe,
          miso_en && rst_n && !hist[hist.size()-2][2]);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_low();
    spi_sel_n = 1'b0; wait_n(8);
  endtask

  task automatic sel_high();
    wait_n(8); spi_sel_n = 1'b1; wait_n(8);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = mo[i];
      wait_n(8);
      mi[i] = spi_miso;
      spi_sck = 1'b1;
      wait_n(8);
      spi_sck = 1'b0;
    end
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_valid = 1'b1; tx_data = b; wait_n(1); tx_valid = 1'b0;
  endtask

  task automatic read_rx();
    rx_ready = 1'b1; wait_n(1); rx_ready = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] mi, mi2;
    wait_n(5);
    check(rx_valid == 0, "R1 reset rx_valid", rx_valid, 0);
    check(tx_ready == 1, "R1 reset tx_ready", tx_ready, 1);
    check(spi_miso_oe == 0, "R1 reset miso_oe", spi_miso_oe, 0);
    rst_n = 1'b1;
    wait_n(4);
    check(rx_data == 8'h00 && spi_miso == 0, "R1 idle data", rx_data, 0);

    // first byte
    miso_en = 1'b1;
    write_tx(8'hA5);
    wait_n(1);
    check(tx_ready == 0, "R7 holding full", tx_ready, 0);
    sel_low();
    check(tx_ready == 1, "R7 consumed at select fall", tx_ready, 1);
    check(spi_miso_oe == 1, "R4 oe while selected", spi_miso_oe, 1);
    xfer(8'h3C, 8, mi);
    sel_high();
    check(rx_valid == 1, "R2 byte received", rx_valid, 1);
    check(rx_data == 8'h3C, "R2 byte value", rx_data, 8'h3C);
    check(mi == 8'hA5, "R3 transmitted byte", mi, 8'hA5);
    check(spi_miso_oe == 0, "R4 oe released", spi_miso_oe, 0);

    read_rx();
    wait_n(1);
    check(rx_valid == 0, "R6 handshake clears", rx_valid, 0);

    // aborted byte then aligned byte
    write_tx(8'h0F);
    sel_low();
    xfer(8'hE7, 4, mi);
    sel_high();
    check(rx_valid == 0, "R5 abort sets no valid", rx_valid, 0);
    check(rx_data == 8'h3C, "R5 abort keeps data", rx_data, 8'h3C);
    write_tx(8'h81);
    sel_low();
    xfer(8'h5A, 8, mi);
    sel_high();
    check(rx_data == 8'h5A, "R5 realigned rx", rx_data, 8'h5A);
    check(mi == 8'h81, "R5 realigned tx", mi, 8'h81);

    // untaken byte overwritten; empty holding sends zero
    sel_low();
    xfer(8'hC3, 8, mi);
    sel_high();
    check(rx_valid == 1 && rx_data == 8'hC3, "R6 overwrite", rx_data, 8'hC3);
    check(mi == 8'h00, "R7 empty sends zero", mi, 8'h00);

    // two bytes in one frame
    read_rx();
    write_tx(8'h11);
    sel_low();
    write_tx(8'h33);
    xfer(8'h22, 8, mi);
    xfer(8'h44, 8, mi2);
    sel_high();
    check(mi == 8'h11, "R8 first tx byte", mi, 8'h11);
    check(mi2 == 8'h33, "R8 second tx byte", mi2, 8'h33);
    check(rx_valid == 1 && rx_data == 8'h44, "R8 second rx byte", rx_data, 8'h44);

    // output enable gated by host
    miso_en = 1'b0;
    sel_low();
    check(spi_miso_oe == 0, "R4 oe off when disabled", spi_miso_oe, 0);
    sel_high();
    miso_en = 1'b1;

    // bus activity while deselected
    read_rx();
    wait_n(2);
    xfer(8'hFF, 8, mi);
    wait_n(8);
    check(rx_valid == 0, "R9 idle no valid", rx_valid, 0);
    check(rx_data == 8'h44, "R9 idle keeps data", rx_data, 8'h44);
    check(spi_miso_oe == 0, "R9 idle oe off", spi_miso_oe, 0);

    // framing still aligned afterwards
    sel_low();
    xfer(8'h96, 8, mi);
    sel_high();
    check(rx_data == 8'h96, "R9 later frame aligned", rx_data, 8'h96);

    done_flag = 1;
    wait_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule